// File: doc/BRIEF.md
# Segment Pair Link Checker

This block judges whether two track segments, each recorded in a different detector station, could have been left by one charged particle that came from the interaction point. Each segment arrives as a record with a valid bit, a station code, a coarse polar coordinate (eta), a fine azimuth (phi), a bend-direction bit, a straight-through flag and a two-bit quality. The block runs a fixed set of geometric and bending tests on the pair. It returns a link-valid bit and a link quality one clock after the pair is presented.

The accepted eta range, the allowed eta mismatch and three tables of maximum azimuth difference are programmable through a simple register write port. The three tables belong to three momentum thresholds, and each holds one limit for each of eight coarse eta bins. A higher threshold comes with a tighter limit. The highest threshold whose limit the pair meets becomes the momentum grade in the link quality.

Top module: `seg_link_check`

## Requirements
- R1: A link is formed only when both segment valid bits are 1; otherwise link_vld is 0 and link_q is 0 in the next cycle.
- R2: Station codes are 0 to 3 for the first to fourth station. A pair whose two codes are equal, or which joins code 0 with code 3 in either order, is rejected.
- R3: The eta of each segment must satisfy lo <= eta <= hi, both ends inclusive. The bound lo is written at address 24 and hi at address 25.
- R4: The absolute difference between the two eta values must not exceed the tolerance written at address 26. The test is the same whichever segment has the larger eta.
- R5: The azimuth difference is d = b_phi - a_phi, taken without wrap-around. If d > 0, every segment that is not flagged straight must have bend bit 1. If d < 0, every such segment must have bend bit 0. If d = 0, the bend bits are not tested.
- R6: A pair in which both segments are flagged straight-through is rejected.
- R7: The limit index is bits 5:3 of a_eta. The limit for threshold t and index i sits at address t*8+i. The pair is rejected unless |d| <= limit(0, index).
- R8: The momentum grade is 1 plus the highest threshold t (0 to 2) for which |d| <= limit(t, index). The boundary value |d| equal to the limit counts as passing.
- R9: link_q is {grade[1:0], min(a_qual, b_qual)[1:0]} when the link is formed. It is 0 whenever any test fails.
- R10: Outputs follow the inputs with one clock of latency. A configuration write affects pairs presented in the cycles after the write cycle.
- R11: Reset clears link_vld and link_q. After reset all limits are 0, lo is 0, hi is 63 and the tolerance is 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address (limits 0-23, lo 24, hi 25, tolerance 26) |
| cfg_wdata | input | 12 | Configuration write data |
| a_vld | input | 1 | Segment A valid |
| a_sta | input | 2 | Segment A station code |
| a_eta | input | 6 | Segment A eta |
| a_phi | input | 12 | Segment A phi |
| a_bend | input | 1 | Segment A bend direction (1 = increasing phi) |
| a_straight | input | 1 | Segment A parallel to beam axis |
| a_qual | input | 2 | Segment A quality |
| b_vld | input | 1 | Segment B valid |
| b_sta | input | 2 | Segment B station code |
| b_eta | input | 6 | Segment B eta |
| b_phi | input | 12 | Segment B phi |
| b_bend | input | 1 | Segment B bend direction |
| b_straight | input | 1 | Segment B parallel to beam axis |
| b_qual | input | 2 | Segment B quality |
| link_vld | output | 1 | Pair accepted as one track |
| link_q | output | 4 | Link quality {grade, minimum segment quality} |

## Verification
A vector table sweeps the azimuth difference across each threshold limit, from one unit inside to one unit outside and at the exact value. It does this for both signs and for the eight-bin with tighter limits. These vectors separate an inclusive comparison from a strict one and confirm that the A-side eta picks the table row. Other vectors move each eta to one unit inside and one unit outside the window and the tolerance, swap the station order, and flip bend bits with and without the straight flag. Each of these shows which single test rejected the pair. Directed steps check the values left by reset, and they write a limit in the same cycle a pair is judged, which shows that the new value applies only from the next cycle.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic [1:0] {
    STA_FIRST  = 2'd0,
    STA_SECOND = 2'd1,
    STA_THIRD  = 2'd2,
    STA_FOURTH = 2'd3
  } station_e;
endpackage

// File: rtl/slc_cfg_regs.sv
module slc_cfg_regs #(
  parameter int ETA_W  = 6,
  parameter int LIM_W  = 12,
  parameter int N_THR  = 3,
  parameter int N_IDX  = 8,
  parameter int ADDR_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [LIM_W-1:0]               wdata,
  output logic [ETA_W-1:0]               eta_lo,
  output logic [ETA_W-1:0]               eta_hi,
  output logic [ETA_W-1:0]               eta_tol,
  output logic [N_THR*N_IDX*LIM_W-1:0]   lim_flat
);
  localparam int N_LIM = N_THR * N_IDX;
  localparam int A_LO  = N_LIM;
  localparam int A_HI  = N_LIM + 1;
  localparam int A_TOL = N_LIM + 2;

  for (genvar i = 0; i < N_LIM; i++) begin : g_lim
    logic [LIM_W-1:0] lim_q, lim_d;
    logic             hit;
    assign hit = we && (addr == ADDR_W'(i));
    always_comb lim_d = hit ? wdata : lim_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lim_q <= '0;
      else        lim_q <= lim_d;
    end
    assign lim_flat[i*LIM_W +: LIM_W] = lim_q;
  end

  logic [ETA_W-1:0] lo_d, hi_d, tol_d;
  always_comb begin
    lo_d  = (we && addr == ADDR_W'(A_LO))  ? wdata[ETA_W-1:0] : eta_lo;
    hi_d  = (we && addr == ADDR_W'(A_HI))  ? wdata[ETA_W-1:0] : eta_hi;
    tol_d = (we && addr == ADDR_W'(A_TOL)) ? wdata[ETA_W-1:0] : eta_tol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eta_lo  <= '0;
      eta_hi  <= '1;
      eta_tol <= '1;
    end else begin
      eta_lo  <= lo_d;
      eta_hi  <= hi_d;
      eta_tol <= tol_d;
    end
  end
endmodule

// File: rtl/slc_geo_tests.sv
module slc_geo_tests
  import slc_pkg::*;
#(
  parameter int ETA_W = 6,
  parameter int PHI_W = 12
) (
  input  logic             a_vld,
  input  logic [1:0]       a_sta,
  input  logic [ETA_W-1:0] a_eta,
  input  logic [PHI_W-1:0] a_phi,
  input  logic             a_bend,
  input  logic             a_straight,
  input  logic             b_vld,
  input  logic [1:0]       b_sta,
  input  logic [ETA_W-1:0] b_eta,
  input  logic [PHI_W-1:0] b_phi,
  input  logic             b_bend,
  input  logic             b_straight,
  input  logic [ETA_W-1:0] eta_lo,
  input  logic [ETA_W-1:0] eta_hi,
  input  logic [ETA_W-1:0] eta_tol,
  output logic             ok_geo,
  output logic [PHI_W-1:0] dphi_abs
);
  logic [PHI_W:0]   dphi;
  logic             d_neg, d_zero;
  logic [ETA_W-1:0] deta;
  logic             ok_vld, ok_sta, ok_win, ok_eta, ok_bend, ok_str;
  station_e         sa, sb;

  always_comb begin
    sa       = station_e'(a_sta);
    sb       = station_e'(b_sta);
    dphi     = {1'b0, b_phi} - {1'b0, a_phi};
    d_neg    = dphi[PHI_W];
    d_zero   = (dphi == '0);
    dphi_abs = d_neg ? PHI_W'(-dphi) : dphi[PHI_W-1:0];
    deta     = (a_eta >= b_eta) ? (a_eta - b_eta) : (b_eta - a_eta);

    ok_vld  = a_vld && b_vld;
    ok_sta  = (sa != sb) &&
              !((sa == STA_FIRST  && sb == STA_FOURTH) ||
                (sa == STA_FOURTH && sb == STA_FIRST));
    ok_win  = (a_eta >= eta_lo) && (a_eta <= eta_hi) &&
              (b_eta >= eta_lo) && (b_eta <= eta_hi);
    ok_eta  = (deta <= eta_tol);
    ok_bend = d_zero ||
              ((a_straight || (a_bend == !d_neg)) &&
               (b_straight || (b_bend == !d_neg)));
    ok_str  = !(a_straight && b_straight);
    ok_geo  = ok_vld && ok_sta && ok_win && ok_eta && ok_bend && ok_str;
  end
endmodule

// File: rtl/slc_pt_grade.sv
module slc_pt_grade #(
  parameter int LIM_W = 12,
  parameter int N_THR = 3,
  parameter int IDX_W = 3,
  parameter int GR_W  = 2
) (
  input  logic [LIM_W-1:0]                    dphi_abs,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [N_THR*(1<<IDX_W)*LIM_W-1:0]   lim_flat,
  output logic                                ok_base,
  output logic [GR_W-1:0]                     grade
);
  localparam int N_IDX = 1 << IDX_W;

  logic [N_THR-1:0] pass;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic [LIM_W-1:0] row [N_IDX];
    for (genvar i = 0; i < N_IDX; i++) begin : g_ent
      assign row[i] = lim_flat[(t*N_IDX + i)*LIM_W +: LIM_W];
    end
    assign pass[t] = (dphi_abs <= row[idx]);
  end

  always_comb begin
    ok_base = pass[0];
    grade   = '0;
    for (int t = 0; t < N_THR; t++) begin
      if (pass[t]) grade = GR_W'(t + 1);
    end
  end
endmodule

// File: rtl/seg_link_check.sv
module seg_link_check #(
  parameter int ETA_W = 6,
  parameter int PHI_W = 12,
  parameter int Q_W   = 2,
  parameter int N_THR = 3,
  parameter int IDX_W = 3,
  localparam int N_IDX  = 1 << IDX_W,
  localparam int ADDR_W = $clog2(N_THR*N_IDX + 3),
  localparam int GR_W   = $clog2(N_THR + 1),
  localparam int LQ_W   = GR_W + Q_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [PHI_W-1:0]  cfg_wdata,
  input  logic              a_vld,
  input  logic [1:0]        a_sta,
  input  logic [ETA_W-1:0]  a_eta,
  input  logic [PHI_W-1:0]  a_phi,
  input  logic              a_bend,
  input  logic              a_straight,
  input  logic [Q_W-1:0]    a_qual,
  input  logic              b_vld,
  input  logic [1:0]        b_sta,
  input  logic [ETA_W-1:0]  b_eta,
  input  logic [PHI_W-1:0]  b_phi,
  input  logic              b_bend,
  input  logic              b_straight,
  input  logic [Q_W-1:0]    b_qual,
  output logic              link_vld,
  output logic [LQ_W-1:0]   link_q
);
  logic [ETA_W-1:0]              eta_lo, eta_hi, eta_tol;
  logic [N_THR*N_IDX*PHI_W-1:0]  lim_flat;
  logic                          ok_geo, ok_base;
  logic [PHI_W-1:0]              dphi_abs;
  logic [GR_W-1:0]               grade;
  logic [Q_W-1:0]                q_min;
  logic                          vld_d;
  logic [LQ_W-1:0]               q_d;

  slc_cfg_regs #(
    .ETA_W(ETA_W), .LIM_W(PHI_W), .N_THR(N_THR), .N_IDX(N_IDX), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .eta_lo(eta_lo), .eta_hi(eta_hi), .eta_tol(eta_tol), .lim_flat(lim_flat)
  );

  slc_geo_tests #(.ETA_W(ETA_W), .PHI_W(PHI_W)) u_geo (
    .a_vld(a_vld), .a_sta(a_sta), .a_eta(a_eta), .a_phi(a_phi),
    .a_bend(a_bend), .a_straight(a_straight),
    .b_vld(b_vld), .b_sta(b_sta), .b_eta(b_eta), .b_phi(b_phi),
    .b_bend(b_bend), .b_straight(b_straight),
    .eta_lo(eta_lo), .eta_hi(eta_hi), .eta_tol(eta_tol),
    .ok_geo(ok_geo), .dphi_abs(dphi_abs)
  );

  slc_pt_grade #(
    .LIM_W(PHI_W), .N_THR(N_THR), .IDX_W(IDX_W), .GR_W(GR_W)
  ) u_grade (
    .dphi_abs(dphi_abs), .idx(a_eta[ETA_W-1 -: IDX_W]), .lim_flat(lim_flat),
    .ok_base(ok_base), .grade(grade)
  );

  always_comb begin
    q_min = (a_qual < b_qual) ? a_qual : b_qual;
    vld_d = ok_geo && ok_base;
    q_d   = vld_d ? {grade, q_min} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_vld <= 1'b0;
      link_q   <= '0;
    end else begin
      link_vld <= vld_d;
      link_q   <= q_d;
    end
  end
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
  parameter int LQ_W = 4,
  parameter int Q_W  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            a_vld,
  input logic            b_vld,
  input logic [1:0]      a_sta,
  input logic [1:0]      b_sta,
  input logic            a_straight,
  input logic            b_straight,
  input logic            link_vld,
  input logic [LQ_W-1:0] link_q
);
  // R1: a missing segment never yields a link
  p_need_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_vld || !b_vld) |=> !link_vld);

  // R2: equal stations or a first-fourth pair are rejected
  p_sta_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_sta == b_sta) || ({a_sta, b_sta} == 4'b0011) || ({a_sta, b_sta} == 4'b1100))
      |=> !link_vld);

  // R6: two straight-through segments are rejected
  p_straight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_straight && b_straight) |=> !link_vld);

  // R9: quality is zero without a link
  p_qzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !link_vld |-> (link_q == '0));

  // R8: a formed link always carries a nonzero grade
  p_grade_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_vld |-> (link_q[LQ_W-1:Q_W] != '0));
endmodule

bind seg_link_check slc_checker #(.LQ_W(LQ_W), .Q_W(Q_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_vld(a_vld), .b_vld(b_vld),
  .a_sta(a_sta), .b_sta(b_sta), .a_straight(a_straight), .b_straight(b_straight),
  .link_vld(link_vld), .link_q(link_q)
);

// File: tb/sim_seg_link_check.sv
module sim_seg_link_check;
  logic        clk, rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic        a_vld, b_vld, a_bend, b_bend, a_straight, b_straight;
  logic [1:0]  a_sta, b_sta, a_qual, b_qual;
  logic [5:0]  a_eta, b_eta;
  logic [11:0] a_phi, b_phi;
  logic        link_vld;
  logic [3:0]  link_q;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  seg_link_check u0 (.*);

  initial clk = 0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  sa, sb;
    logic        av, bv;
    logic [5:0]  ea, eb;
    logic [11:0] pa, pb;
    logic        ba, bb, ta, tb;
    logic [1:0]  qa, qb;
    logic        ev;
    logic [3:0]  eq;
  } vec_t;

  localparam int NV = 28;
  // config in force: lo=8 hi=60 tol=3; rows 0-6 limits 400/100/20, row 7 limits 50/30/10
  localparam vec_t VEC [NV] = '{
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b1,4'd14}, // R8 grade 3
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1050,1'b1,1'b1,1'b0,1'b0,2'd1,2'd3,1'b1,4'd9},  // R8 grade 2
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd700, 1'b0,1'b0,1'b0,1'b0,2'd2,2'd2,1'b1,4'd6},  // R5 negative
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd599, 1'b0,1'b0,1'b0,1'b0,2'd2,2'd2,1'b0,4'd0},  // R7 over by one
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd600, 1'b0,1'b0,1'b0,1'b0,2'd2,2'd2,1'b1,4'd6},  // R7 at limit
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1020,1'b1,1'b1,1'b0,1'b0,2'd3,2'd3,1'b1,4'd15}, // R8 at top limit
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1021,1'b1,1'b1,1'b0,1'b0,2'd3,2'd3,1'b1,4'd11}, // R8 one over
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1015,1'b0,1'b1,1'b0,1'b0,2'd3,2'd2,1'b0,4'd0},  // R5 bend clash
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1015,1'b0,1'b1,1'b1,1'b0,2'd3,2'd2,1'b1,4'd14}, // R5 straight exempt
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1000,1'b1,1'b1,1'b1,1'b1,2'd3,2'd2,1'b0,4'd0},  // R6 both straight
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1000,1'b0,1'b1,1'b0,1'b0,2'd2,2'd2,1'b1,4'd14}, // R5 zero diff
    '{2'd1,2'd2,1'b0,1'b1,6'd20,6'd21,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b0,4'd0},  // R1 A invalid
    '{2'd1,2'd2,1'b1,1'b0,6'd20,6'd21,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b0,4'd0},  // R1 B invalid
    '{2'd0,2'd3,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b0,4'd0},  // R2 first-fourth
    '{2'd3,2'd0,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b0,4'd0},  // R2 fourth-first
    '{2'd2,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b0,4'd0},  // R2 same station
    '{2'd0,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b1,4'd14}, // R2 first-third ok
    '{2'd1,2'd2,1'b1,1'b1,6'd7, 6'd8, 12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b0,4'd0},  // R3 below lo
    '{2'd1,2'd2,1'b1,1'b1,6'd8, 6'd8, 12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b1,4'd14}, // R3 at lo
    '{2'd1,2'd2,1'b1,1'b1,6'd60,6'd61,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b0,4'd0},  // R3 above hi
    '{2'd1,2'd2,1'b1,1'b1,6'd60,6'd60,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b1,4'd10}, // R3 at hi, row 7
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd24,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b0,4'd0},  // R4 diff 4
    '{2'd1,2'd2,1'b1,1'b1,6'd24,6'd20,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b0,4'd0},  // R4 diff 4 swapped
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd23,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b1,4'd14}, // R4 diff 3
    '{2'd1,2'd2,1'b1,1'b1,6'd58,6'd58,12'd1000,12'd1051,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b0,4'd0},  // R7 row 7 over
    '{2'd1,2'd2,1'b1,1'b1,6'd58,6'd58,12'd1000,12'd1040,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b1,4'd6},  // R8 row 7 grade 1
    '{2'd1,2'd2,1'b1,1'b1,6'd20,6'd21,12'd1000,12'd1015,1'b1,1'b1,1'b0,1'b0,2'd0,2'd3,1'b1,4'd12}, // R9 min quality 0
    '{2'd1,2'd2,1'b1,1'b1,6'd55,6'd57,12'd1000,12'd1045,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,1'b1,4'd10}  // R7 row from A eta
  };

  task automatic check(input logic ev, input logic [3:0] eq, input string tag);
    checks++;
    if (link_vld !== ev || link_q !== eq) begin
      errors++;
      $display("FAIL %s: link_vld=%0d link_q=%0d expected %0d %0d", tag, link_vld, link_q, ev, eq);
    end
  endtask

  task automatic apply(input vec_t v);
    a_sta = v.sa; b_sta = v.sb; a_vld = v.av; b_vld = v.bv;
    a_eta = v.ea; b_eta = v.eb; a_phi = v.pa; b_phi = v.pb;
    a_bend = v.ba; b_bend = v.bb; a_straight = v.ta; b_straight = v.tb;
    a_qual = v.qa; b_qual = v.qb;
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5'(addr); cfg_wdata = 12'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    vec_t v;
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    v = VEC[0];
    apply(v);
    repeat (3) @(posedge clk);
    #1 check(1'b0, 4'd0, "R11 outputs in reset");
    @(negedge clk) rst_n = 1;

    // R11: default config, limits 0, full window, full tolerance
    v = VEC[0]; v.ea = 6'd0; v.eb = 6'd63; v.pb = 12'd1000; v.qa = 2'd3; v.qb = 2'd3;
    apply(v);
    @(posedge clk); #1 check(1'b1, 4'd15, "R11 default zero diff");
    @(negedge clk) b_phi = 12'd1001;
    @(posedge clk); #1 check(1'b0, 4'd0, "R11 default limit zero");

    for (int i = 0; i < 7; i++) begin
      cfg_write(i, 400); cfg_write(8 + i, 100); cfg_write(16 + i, 20);
    end
    cfg_write(7, 50); cfg_write(15, 30); cfg_write(23, 10);
    cfg_write(24, 8); cfg_write(25, 60); cfg_write(26, 3);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) apply(VEC[i]);
      @(posedge clk); #1 check(VEC[i].ev, VEC[i].eq, $sformatf("R3-table vec %0d", i));
    end

    // R10: write in the same cycle as a pair; new limit only from next cycle
    @(negedge clk);
    apply(VEC[0]);
    cfg_we = 1; cfg_addr = 5'd18; cfg_wdata = 12'd10;
    @(posedge clk); #1 check(1'b1, 4'd14, "R10 old limit in write cycle");
    @(negedge clk) cfg_we = 0;
    @(posedge clk); #1 check(1'b1, 4'd10, "R10 new limit after write");

    // R10: one cycle latency on a falling link
    @(negedge clk) a_vld = 0;
    #1 check(1'b1, 4'd10, "R10 output holds before edge");
    @(posedge clk); #1 check(1'b0, 4'd0, "R1 drop after one cycle");

    done = 1;
    finish_run();
  end
endmodule